// File: doc/BRIEF.md
# Residue-to-binary converter for the (8, 7, 5, 3) modulus set

This block takes a number held as four residues (remainders modulo 8, 7, 5 and 3) and returns its ordinary binary value. The four moduli are pairwise coprime, so every integer from 0 to 839 has exactly one residue tuple, and 840 is the dynamic range. Arithmetic pipelines that add and multiply lane by lane in residue form use this block to convert a result back to binary at the end.

The conversion uses position weights from the Chinese Remainder Theorem. Each residue digit picks a precomputed term, `(digit * weight) mod 840`, from a small per-lane table. The four lanes hold 8 + 7 + 5 + 3 = 23 entries in total. Three modular adders combine the four terms. A second view of the result reads the upper half of the range as negative numbers. In residue form a negative number is written by taking each digit's complement against its modulus, so this view recovers values from -420 to 419. Both results are registered, and a valid flag travels with them.

Top module: `rns_crt_decode`

## Requirements
- R1: For every integer v from 0 to 839, the input tuple (v mod 8, v mod 7, v mod 5, v mod 3) on (res_m8, res_m7, res_m5, res_m3) produces out_unsigned = v.
- R2: out_unsigned equals (105·res_m8 + 120·res_m7 + 336·res_m5 + 280·res_m3) mod 840. For example, (1, 2, 4, 0) gives 9 and (0, 1, 3, 2) gives 8.
- R3: out_unsigned never reaches 840 or more.
- R4: out_signed equals out_unsigned − 840 when out_unsigned is 420 or more, and equals out_unsigned otherwise. Its range is therefore −420 to 419, in two's complement.
- R5: out_valid is high in exactly the cycles that follow a cycle with in_valid high. The results of an input sampled at one rising edge appear after that same edge. Inputs marked valid on back-to-back cycles produce results on back-to-back cycles.
- R6: While in_valid is low, out_unsigned and out_signed keep their last values, whatever the residue inputs do.
- R7: While rst is high at a rising edge, out_valid, out_unsigned and out_signed become 0, even if in_valid is high.
- R8: Complementing each digit against its modulus negates the signed result. For example, (5, 0, 1, 0) gives 21 and (3, 0, 4, 0) gives −21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Residue tuple on the inputs is valid this cycle |
| res_m8 | input | 3 | Residue modulo 8 (0..7) |
| res_m7 | input | 3 | Residue modulo 7 (0..6) |
| res_m5 | input | 3 | Residue modulo 5 (0..4) |
| res_m3 | input | 2 | Residue modulo 3 (0..2) |
| out_valid | output | 1 | Results below belong to a tuple from the previous cycle |
| out_unsigned | output | 10 | Binary value, 0..839 |
| out_signed | output | 11 | Same value read as signed, −420..419 |

## Verification
Every result is due one rising edge after the edge that samples its in_valid tuple. The bench drives inputs at the falling edge and reads the outputs at the next falling edge, which is half a period after the single register has captured them. The streaming sweep over all 840 values checks the output of the previous cycle before it drives the next tuple, so back-to-back delivery is checked at the same one-cycle offset. The hold and reset checks read the outputs at the falling edge that follows the cycle in which the outputs could have changed.

// File: rtl/rns_crt_pkg.sv
package rns_crt_pkg;

    localparam int NUM_LANES = 4;
    localparam int MODULI [NUM_LANES] = '{8, 7, 5, 3};
    localparam int RANGE  = MODULI[0] * MODULI[1] * MODULI[2] * MODULI[3];
    localparam int HALF   = RANGE / 2;
    localparam int VAL_W  = $clog2(RANGE);
    localparam int SGN_W  = VAL_W + 1;
    localparam int DIG_W  = $clog2(MODULI[0]);

    typedef logic [VAL_W-1:0] val_t;
    typedef logic [DIG_W-1:0] dig_t;

    typedef struct packed {
        logic                    valid;
        val_t                    mag;
        logic signed [SGN_W-1:0] sgn;
    } crt_out_t;

    // Position weight: (RANGE/m) times its inverse modulo m
    function automatic int crt_weight(input int lane);
        int m;
        int part;
        int w;
        m    = MODULI[lane];
        part = RANGE / m;
        w    = 0;
        for (int a = 1; a < m; a++) begin
            if ((part * a) % m == 1) w = part * a;
        end
        return w;
    endfunction

    function automatic int crt_term(input int lane, input int digit);
        return (digit * crt_weight(lane)) % RANGE;
    endfunction

endpackage

// File: rtl/crt_term_lut.sv
module crt_term_lut
    import rns_crt_pkg::*;
#(
    parameter int LANE = 0
) (
    input  dig_t digit,
    output val_t term
);
    localparam int MOD = MODULI[LANE];

    val_t table_q [MOD];

    for (genvar e = 0; e < MOD; e++) begin : g_entry
        assign table_q[e] = val_t'(crt_term(LANE, e));
    end

    always_comb begin
        term = '0;
        for (int i = 0; i < MOD; i++) begin
            if (digit == DIG_W'(i)) term = table_q[i];
        end
    end
endmodule

// File: rtl/crt_mod_add.sv
module crt_mod_add
    import rns_crt_pkg::*;
(
    input  val_t a,
    input  val_t b,
    output val_t sum
);
    logic [VAL_W:0] raw;
    logic [VAL_W:0] folded;

    always_comb begin
        raw    = {1'b0, a} + {1'b0, b};
        folded = raw - (VAL_W+1)'(RANGE);
        sum    = (raw >= (VAL_W+1)'(RANGE)) ? folded[VAL_W-1:0] : raw[VAL_W-1:0];
    end
endmodule

// File: rtl/rns_crt_decode.sv
module rns_crt_decode
    import rns_crt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [2:0]              res_m8,
    input  logic [2:0]              res_m7,
    input  logic [2:0]              res_m5,
    input  logic [1:0]              res_m3,
    output logic                    out_valid,
    output logic [VAL_W-1:0]        out_unsigned,
    output logic signed [SGN_W-1:0] out_signed
);
    dig_t     dig  [NUM_LANES];
    val_t     term [NUM_LANES];
    val_t     pair_hi;
    val_t     pair_lo;
    val_t     total;
    crt_out_t next_d;
    crt_out_t out_q;

    assign dig[0] = DIG_W'(res_m8);
    assign dig[1] = DIG_W'(res_m7);
    assign dig[2] = DIG_W'(res_m5);
    assign dig[3] = DIG_W'(res_m3);

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        crt_term_lut #(.LANE(l)) u_lut (
            .digit (dig[l]),
            .term  (term[l])
        );
    end

    crt_mod_add u_add_hi  (.a(term[0]), .b(term[1]), .sum(pair_hi));
    crt_mod_add u_add_lo  (.a(term[2]), .b(term[3]), .sum(pair_lo));
    crt_mod_add u_add_top (.a(pair_hi), .b(pair_lo), .sum(total));

    always_comb begin
        next_d.valid = in_valid;
        next_d.mag   = total;
        if (total >= VAL_W'(HALF))
            next_d.sgn = SGN_W'(total) - SGN_W'(RANGE);
        else
            next_d.sgn = SGN_W'(total);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= next_d.valid;
            if (in_valid) begin
                out_q.mag <= next_d.mag;
                out_q.sgn <= next_d.sgn;
            end
        end
    end

    assign out_valid    = out_q.valid;
    assign out_unsigned = out_q.mag;
    assign out_signed   = out_q.sgn;
endmodule

// File: rtl/rns_crt_decode_check.sv
module rns_crt_decode_check
    import rns_crt_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [2:0]              res_m8,
    input logic [2:0]              res_m7,
    input logic [2:0]              res_m5,
    input logic [1:0]              res_m3,
    input logic                    out_valid,
    input logic [VAL_W-1:0]        out_unsigned,
    input logic signed [SGN_W-1:0] out_signed
);
    assert_residue_match_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && res_m7 < 3'd7 && res_m5 < 3'd5 && res_m3 < 2'd3) |=>
        (int'(out_unsigned) % 8 == int'($past(res_m8)) &&
         int'(out_unsigned) % 7 == int'($past(res_m7)) &&
         int'(out_unsigned) % 5 == int'($past(res_m5)) &&
         int'(out_unsigned) % 3 == int'($past(res_m3))));

    assert_below_range_R3: assert property (@(posedge clk) disable iff (rst)
        int'(out_unsigned) < RANGE);

    assert_signed_view_R4: assert property (@(posedge clk) disable iff (rst)
        ((int'(out_signed) - int'(out_unsigned) == 0) ||
         (int'(out_signed) - int'(out_unsigned) == -RANGE)) &&
        int'(out_signed) >= -HALF && int'(out_signed) < HALF);

    assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drop_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_unsigned) && $stable(out_signed)));
endmodule

bind rns_crt_decode rns_crt_decode_check u_check (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .res_m8       (res_m8),
    .res_m7       (res_m7),
    .res_m5       (res_m5),
    .res_m3       (res_m3),
    .out_valid    (out_valid),
    .out_unsigned (out_unsigned),
    .out_signed   (out_signed)
);

// File: tb/rns_crt_decode_bench.sv
module rns_crt_decode_bench;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic [2:0]         res_m8;
    logic [2:0]         res_m7;
    logic [2:0]         res_m5;
    logic [1:0]         res_m3;
    logic               out_valid;
    logic [9:0]         out_unsigned;
    logic signed [10:0] out_signed;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rns_crt_decode u_rns_crt_decode (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .res_m8       (res_m8),
        .res_m7       (res_m7),
        .res_m5       (res_m5),
        .res_m3       (res_m3),
        .out_valid    (out_valid),
        .out_unsigned (out_unsigned),
        .out_signed   (out_signed)
    );

    // tuple (m8, m7, m5, m3) and expected unsigned value
    localparam int VEC_N = 9;
    localparam int V8 [VEC_N] = '{1, 0, 0, 1, 5, 3, 7, 4, 3};
    localparam int V7 [VEC_N] = '{2, 1, 0, 1, 0, 0, 6, 0, 6};
    localparam int V5 [VEC_N] = '{4, 3, 0, 1, 1, 4, 4, 0, 4};
    localparam int V3 [VEC_N] = '{0, 2, 0, 1, 0, 0, 2, 0, 2};
    localparam int VX [VEC_N] = '{9, 8, 0, 1, 21, 819, 839, 420, 419};

    function automatic int signed_of(input int u);
        return (u >= 420) ? u - 840 : u;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int d8, input int d7, input int d5, input int d3, input bit v);
        res_m8   = 3'(d8);
        res_m7   = 3'(d7);
        res_m5   = 3'(d5);
        res_m3   = 2'(d3);
        in_valid = v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int neg_a;
        int hold_u;
        int hold_s;
        rst = 1'b1;
        drive(0, 0, 0, 0, 1'b0);
        repeat (3) @(negedge clk);
        // R7 reset state
        chk("R7 reset out_valid", int'(out_valid), 0);
        chk("R7 reset out_unsigned", int'(out_unsigned), 0);
        chk("R7 reset out_signed", int'(out_signed), 0);
        rst = 1'b0;

        // R2 / R4 / R5 table vectors, one at a time
        for (int i = 0; i < VEC_N; i++) begin
            @(negedge clk);
            drive(V8[i], V7[i], V5[i], V3[i], 1'b1);
            @(negedge clk);
            in_valid = 1'b0;
            chk($sformatf("R2 vector %0d unsigned", i), int'(out_unsigned), VX[i]);
            chk($sformatf("R4 vector %0d signed", i), int'(out_signed), signed_of(VX[i]));
            chk($sformatf("R5 vector %0d valid", i), int'(out_valid), 1);
        end

        // R6 hold: inputs change with in_valid low
        hold_u = int'(out_unsigned);
        hold_s = int'(out_signed);
        drive(7, 6, 4, 2, 1'b0);
        @(negedge clk);
        chk("R6 hold out_valid", int'(out_valid), 0);
        chk("R6 hold out_unsigned", int'(out_unsigned), hold_u);
        chk("R6 hold out_signed", int'(out_signed), hold_s);

        // R8 complement negates the signed result
        drive(5, 0, 1, 0, 1'b1);
        @(negedge clk);
        neg_a = int'(out_signed);
        chk("R8 positive 21", neg_a, 21);
        drive(3, 0, 4, 0, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 negated -21", int'(out_signed), -neg_a);

        // R1 / R3 / R5 streaming round trip over the whole range
        for (int v = 0; v < 840; v++) begin
            @(negedge clk);
            if (v > 0) begin
                chk($sformatf("R1 round trip %0d", v - 1), int'(out_unsigned), v - 1);
                chk($sformatf("R5 stream valid %0d", v - 1), int'(out_valid), 1);
                chk($sformatf("R4 stream signed %0d", v - 1), int'(out_signed), signed_of(v - 1));
            end
            drive(v % 8, v % 7, v % 5, v % 3, 1'b1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 round trip 839", int'(out_unsigned), 839);
        chk("R3 top of range below 840", int'(out_unsigned < 10'd840), 1);
        @(negedge clk);
        chk("R5 valid drops", int'(out_valid), 0);

        // R7 reset wins over a valid input
        drive(1, 2, 4, 0, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        chk("R7 mid reset out_valid", int'(out_valid), 0);
        chk("R7 mid reset out_unsigned", int'(out_unsigned), 0);
        chk("R7 mid reset out_signed", int'(out_signed), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule